// File: doc/BRIEF.md
# Self-Calibrating Slope Converter Sequencer

This block is the digital side of a single-slope integrating analog-to-digital converter that calibrates itself on every conversion. It owns the only time base in the converter. A free-running phase counter holds the integrator in reset for a fixed number of clocks and then releases it for a fixed ramp window. This pattern repeats at the same period whatever the converter is doing, so the integrating capacitor always sees the same charge history.

When a conversion is requested, the block steers a one-hot source select through three inputs on three successive ramps: the zero input, then the full-scale reference, then the unknown. Between two selects it keeps every select line low for a programmable dead time. The newly selected input then settles for the rest of the reset window. During each ramp the block counts clocks from the release of the integrator until the synchronized comparator first rises. A comparator that never rises gives a saturated count and an overrange flag. When all three counts are stored, they are presented with a one-cycle valid strobe. The ratio arithmetic that follows is outside this block.

Top module: `slope_conv_ctrl`

## Requirements
- R1: The phase counter starts at 0 in the first cycle after reset. `integ_rst` is high for `RST_LEN` cycles and then low for `RAMP_LEN` cycles, with period `RST_LEN+RAMP_LEN`. The pattern is never altered by requests or conversions.
- R2: `sel` is one-hot or zero. Bit 0 selects the zero input, bit 1 the full-scale reference and bit 2 the unknown. All bits are low whenever `busy` is low.
- R3: Selects are break-before-make. At the end of a ramp the active select drops. The next select rises at phase `DEAD_LEN+1` of a reset window and is held through the last ramp cycle.
- R4: A request sampled while idle raises `busy` in the next cycle. The first measurement uses the first reset window that begins after the request cycle, even when that window begins in the very next cycle.
- R5: One conversion measures zero, then full-scale, then unknown, on three consecutive ramps.
- R6: A count is the ramp-cycle index in which the synchronized comparator is first seen rising. Ramp index 0 is the first cycle with `integ_rst` low. Because of the two-stage synchronizer, a comparator that goes high during ramp cycle k gives count k+2.
- R7: After the first rise in a ramp, later comparator toggles in that ramp do not change the count.
- R8: If no rise is seen by the last ramp cycle, the count is all ones and the matching `ovr` bit is set (bit order as in R2). A comparator already high before the ramp starts also gives this result. A rise seen in the last ramp cycle is still a valid count.
- R9: `res_valid` pulses for one cycle, in the cycle after the last ramp cycle of the unknown measurement. `busy` is low in that cycle. Counts and `ovr` do not change while `busy` is low.
- R10: A request while `busy` is high is ignored and does not change the sequence or its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_req | input | 1 | Conversion request, sampled on each clock |
| cmp_in | input | 1 | Asynchronous comparator output, high once the ramp passes the input |
| integ_rst | output | 1 | Integrator reset drive, high holds the capacitor discharged |
| sel | output | 3 | One-hot source select: bit0 zero, bit1 full-scale, bit2 unknown |
| busy | output | 1 | High from request acceptance until the results are presented |
| res_valid | output | 1 | One-cycle strobe marking the three counts valid |
| cnt_zero | output | CNT_W | Count of the zero measurement |
| cnt_full | output | CNT_W | Count of the full-scale measurement |
| cnt_unk | output | CNT_W | Count of the unknown measurement |
| ovr | output | 3 | Overrange flags, same bit order as sel |

## Verification
`busy` is due one cycle after an accepted request. A select is due `DEAD_LEN+1` cycles after phase 0 of its window. A count equals the comparator's first high ramp cycle plus two. `res_valid` is due one cycle after the final ramp cycle. The bench holds a behavioural phase-and-step model updated on each rising edge and compares `integ_rst`, `sel`, `busy` and `res_valid` against it on every falling edge. Counts and flags are checked at the strobe against values derived from the thresholds the bench applied. These cases include the ramp-end boundary, a comparator high before the ramp, and toggles after the trip.

// File: rtl/slopeconv_pkg.sv
package slopeconv_pkg;

    localparam int NUM_SRC = 3;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ARM,
        SQ_DEAD,
        SQ_MEAS
    } seq_state_e;

    typedef enum logic [1:0] {
        SRC_ZERO = 2'd0,
        SRC_FULL = 2'd1,
        SRC_UNK  = 2'd2
    } src_e;

    function automatic logic [NUM_SRC-1:0] src_onehot(input src_e s);
        logic [NUM_SRC-1:0] r;
        r = NUM_SRC'(1) << s;
        return r;
    endfunction

    function automatic src_e src_next(input src_e s);
        src_e r;
        case (s)
            SRC_ZERO: r = SRC_FULL;
            SRC_FULL: r = SRC_UNK;
            default:  r = SRC_ZERO;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/slope_ramp_timer.sv
module slope_ramp_timer #(
    parameter int RST_LEN  = 200000,
    parameter int RAMP_LEN = 1000000,
    parameter int CNT_W    = 22
) (
    input  logic             clk,
    input  logic             rst,
    output logic             integ_rst,
    output logic             win_start,
    output logic             ramp_on,
    output logic             ramp_end,
    output logic [CNT_W-1:0] ramp_idx
);
    localparam int PERIOD = RST_LEN + RAMP_LEN;
    localparam int PH_W   = $clog2(PERIOD);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD - 1);
    localparam logic [PH_W-1:0] PH_RAMP = PH_W'(RST_LEN);

    logic [PH_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= '0;
        else if (phase_q == PH_LAST)
            phase_q <= '0;
        else
            phase_q <= phase_q + 1'b1;
    end

    assign integ_rst = (phase_q < PH_RAMP);
    assign ramp_on   = ~integ_rst;
    assign win_start = (phase_q == '0);
    assign ramp_end  = (phase_q == PH_LAST);
    assign ramp_idx  = CNT_W'(phase_q - PH_RAMP);

endmodule

// File: rtl/slope_cmp_sync.sv
module slope_cmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cmp_in,
    output logic cmp_rise
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst)
            sh_q <= '0;
        else
            sh_q <= {sh_q[STAGES-1:0], cmp_in};
    end

    assign cmp_rise = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/slope_conv_seq.sv
module slope_conv_seq
    import slopeconv_pkg::*;
#(
    parameter int CNT_W    = 22,
    parameter int DEAD_LEN = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     conv_req,
    input  logic                     win_start,
    input  logic                     ramp_on,
    input  logic                     ramp_end,
    input  logic [CNT_W-1:0]         ramp_idx,
    input  logic                     cmp_rise,
    output logic [NUM_SRC-1:0]       sel,
    output logic                     busy,
    output logic                     res_valid,
    output logic [NUM_SRC*CNT_W-1:0] cnt_flat,
    output logic [NUM_SRC-1:0]       ovr
);
    localparam int DW = (DEAD_LEN > 1) ? $clog2(DEAD_LEN) : 1;
    localparam logic [DW-1:0] DEAD_LAST = DW'(DEAD_LEN - 1);

    seq_state_e      state_q;
    src_e            src_q;
    logic [DW-1:0]   dead_q;
    logic            got_q;
    logic            valid_q;
    logic            trip;

    assign trip = (state_q == SQ_MEAS) && ramp_on && cmp_rise && !got_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            src_q   <= SRC_ZERO;
            dead_q  <= '0;
            got_q   <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            case (state_q)
                SQ_IDLE: begin
                    if (conv_req) begin
                        state_q <= SQ_ARM;
                        src_q   <= SRC_ZERO;
                    end
                end
                SQ_ARM: begin
                    if (win_start) begin
                        state_q <= SQ_DEAD;
                        dead_q  <= '0;
                    end
                end
                SQ_DEAD: begin
                    if (dead_q == DEAD_LAST) begin
                        state_q <= SQ_MEAS;
                        got_q   <= 1'b0;
                    end else begin
                        dead_q <= dead_q + 1'b1;
                    end
                end
                default: begin
                    if (trip)
                        got_q <= 1'b1;
                    if (ramp_end) begin
                        if (src_q == SRC_UNK) begin
                            state_q <= SQ_IDLE;
                            valid_q <= 1'b1;
                        end else begin
                            src_q   <= src_next(src_q);
                            state_q <= SQ_ARM;
                        end
                    end
                end
            endcase
        end
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_slot
        logic             mine;
        logic [CNT_W-1:0] cnt_r;
        logic             ovr_r;

        assign mine = (src_q == src_e'(2'(i)));

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_r <= '0;
                ovr_r <= 1'b0;
            end else if (mine && trip) begin
                cnt_r <= ramp_idx;
                ovr_r <= 1'b0;
            end else if (mine && state_q == SQ_MEAS && ramp_end && !got_q) begin
                cnt_r <= '1;
                ovr_r <= 1'b1;
            end
        end

        assign cnt_flat[i*CNT_W +: CNT_W] = cnt_r;
        assign ovr[i] = ovr_r;
    end

    assign sel       = (state_q == SQ_MEAS) ? src_onehot(src_q) : '0;
    assign busy      = (state_q != SQ_IDLE);
    assign res_valid = valid_q;

endmodule

// File: rtl/slope_conv_ctrl.sv
module slope_conv_ctrl
    import slopeconv_pkg::*;
#(
    parameter int CNT_W       = 22,
    parameter int RST_LEN     = 200000,
    parameter int RAMP_LEN    = 1000000,
    parameter int DEAD_LEN    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             conv_req,
    input  logic             cmp_in,
    output logic             integ_rst,
    output logic [2:0]       sel,
    output logic             busy,
    output logic             res_valid,
    output logic [CNT_W-1:0] cnt_zero,
    output logic [CNT_W-1:0] cnt_full,
    output logic [CNT_W-1:0] cnt_unk,
    output logic [2:0]       ovr
);
    logic                     win_start;
    logic                     ramp_on;
    logic                     ramp_end;
    logic [CNT_W-1:0]         ramp_idx;
    logic                     cmp_rise;
    logic [NUM_SRC*CNT_W-1:0] cnt_flat;

    slope_ramp_timer #(
        .RST_LEN (RST_LEN),
        .RAMP_LEN(RAMP_LEN),
        .CNT_W   (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .integ_rst(integ_rst),
        .win_start(win_start),
        .ramp_on  (ramp_on),
        .ramp_end (ramp_end),
        .ramp_idx (ramp_idx)
    );

    slope_cmp_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .cmp_in  (cmp_in),
        .cmp_rise(cmp_rise)
    );

    slope_conv_seq #(
        .CNT_W   (CNT_W),
        .DEAD_LEN(DEAD_LEN)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .conv_req (conv_req),
        .win_start(win_start),
        .ramp_on  (ramp_on),
        .ramp_end (ramp_end),
        .ramp_idx (ramp_idx),
        .cmp_rise (cmp_rise),
        .sel      (sel),
        .busy     (busy),
        .res_valid(res_valid),
        .cnt_flat (cnt_flat),
        .ovr      (ovr)
    );

    assign cnt_zero = cnt_flat[0*CNT_W +: CNT_W];
    assign cnt_full = cnt_flat[1*CNT_W +: CNT_W];
    assign cnt_unk  = cnt_flat[2*CNT_W +: CNT_W];

endmodule

// File: rtl/slope_conv_ctrl_chk.sv
module slope_conv_ctrl_chk #(
    parameter int CNT_W    = 22,
    parameter int RST_LEN  = 200000,
    parameter int RAMP_LEN = 1000000
) (
    input logic             clk,
    input logic             rst,
    input logic             conv_req,
    input logic             integ_rst,
    input logic [2:0]       sel,
    input logic             busy,
    input logic             res_valid,
    input logic [CNT_W-1:0] cnt_zero,
    input logic [CNT_W-1:0] cnt_full,
    input logic [CNT_W-1:0] cnt_unk,
    input logic [2:0]       ovr
);
    int hi_n;
    int lo_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_n <= 0;
            lo_n <= 0;
        end else begin
            hi_n <= integ_rst ? hi_n + 1 : 0;
            lo_n <= integ_rst ? 0 : lo_n + 1;
        end
    end

    p_rst_width_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(integ_rst) |-> hi_n == RST_LEN);

    p_ramp_width_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(integ_rst) |-> lo_n == RAMP_LEN);

    p_sel_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));

    p_idle_sel_low_r2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> sel == 3'b000);

    p_break_first_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(sel) != 3'b000 && sel != $past(sel)) |-> sel == 3'b000);

    p_busy_from_req_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(conv_req));

    p_ovr_sat_r8: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> ((!ovr[0] || cnt_zero == '1) &&
                       (!ovr[1] || cnt_full == '1) &&
                       (!ovr[2] || cnt_unk  == '1)));

    p_valid_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    p_valid_idle_r9: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> !busy);

    p_hold_results_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy)) |-> ($stable(cnt_zero) && $stable(cnt_full) &&
                                     $stable(cnt_unk) && $stable(ovr)));

endmodule

bind slope_conv_ctrl slope_conv_ctrl_chk #(
    .CNT_W   (CNT_W),
    .RST_LEN (RST_LEN),
    .RAMP_LEN(RAMP_LEN)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .conv_req (conv_req),
    .integ_rst(integ_rst),
    .sel      (sel),
    .busy     (busy),
    .res_valid(res_valid),
    .cnt_zero (cnt_zero),
    .cnt_full (cnt_full),
    .cnt_unk  (cnt_unk),
    .ovr      (ovr)
);

// File: tb/slope_conv_ctrl_tb_top.sv
module slope_conv_ctrl_tb_top;
    localparam int CNT_W    = 8;
    localparam int RST_LEN  = 40;
    localparam int RAMP_LEN = 60;
    localparam int DEAD_LEN = 4;
    localparam int PERIOD   = RST_LEN + RAMP_LEN;
    localparam int SAT      = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             conv_req = 1'b0;
    logic             cmp_in = 1'b0;
    logic             integ_rst;
    logic [2:0]       sel;
    logic             busy;
    logic             res_valid;
    logic [CNT_W-1:0] cnt_zero;
    logic [CNT_W-1:0] cnt_full;
    logic [CNT_W-1:0] cnt_unk;
    logic [2:0]       ovr;

    always #10 clk = ~clk;

    slope_conv_ctrl #(
        .CNT_W      (CNT_W),
        .RST_LEN    (RST_LEN),
        .RAMP_LEN   (RAMP_LEN),
        .DEAD_LEN   (DEAD_LEN),
        .SYNC_STAGES(2)
    ) dut_i (
        .clk      (clk),
        .rst      (rst),
        .conv_req (conv_req),
        .cmp_in   (cmp_in),
        .integ_rst(integ_rst),
        .sel      (sel),
        .busy     (busy),
        .res_valid(res_valid),
        .cnt_zero (cnt_zero),
        .cnt_full (cnt_full),
        .cnt_unk  (cnt_unk),
        .ovr      (ovr)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit run_chk = 1'b0;

    // behavioural model: phase, step (0 idle, 1 waiting for window, 2 measuring), source index
    int mph   = 0;
    int mst   = 0;
    int midx  = 0;
    bit mvalid = 1'b0;

    // analog stand-in: trip thresholds per source, optional glitching, optional stuck-high source
    int thr [3] = '{10, 20, 30};
    bit glitch = 1'b0;
    int hi_src = -1;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            mph = 0; mst = 0; midx = 0; mvalid = 1'b0;
        end else begin
            mvalid = 1'b0;
            if (mst == 0) begin
                if (conv_req) begin mst = 1; midx = 0; end
            end else if (mst == 1) begin
                if (mph == 0) mst = 2;
            end else if (mph == PERIOD - 1) begin
                if (midx == 2) begin mst = 0; mvalid = 1'b1; end
                else begin midx = midx + 1; mst = 1; end
            end
            mph = (mph + 1) % PERIOD;
        end
    end

    always @(negedge clk) begin
        int  ri;
        bit  v;
        ri = mph - RST_LEN;
        v  = 1'b0;
        if (mst == 2 && midx == hi_src)
            v = 1'b1;
        else if (mst == 2 && ri >= 0 && ri >= thr[midx]) begin
            v = 1'b1;
            if (glitch && ri >= thr[midx] + 4 && ri < thr[midx] + 10)
                v = (ri % 2) != 0;
        end
        cmp_in <= v;
    end

    always @(negedge clk) begin
        if (!rst && run_chk) begin
            int es;
            es = (mst == 2 && mph >= DEAD_LEN + 1) ? (1 << midx) : 0;
            chk("R1 integ_rst pattern", int'(integ_rst), (mph < RST_LEN) ? 1 : 0);
            chk("R3 sel timing/order (R2 R5)", int'(sel), es);
            chk("R4 busy (R10)", int'(busy), (mst != 0) ? 1 : 0);
            chk("R9 res_valid timing", int'(res_valid), int'(mvalid));
        end
    end

    function automatic int exp_cnt(input int i);
        if (hi_src == i || thr[i] + 2 > RAMP_LEN - 1) return SAT;
        return thr[i] + 2;
    endfunction

    function automatic int exp_ovr(input int i);
        return (hi_src == i || thr[i] + 2 > RAMP_LEN - 1) ? 1 : 0;
    endfunction

    task automatic pulse_req();
        @(negedge clk) conv_req = 1'b1;
        @(negedge clk) conv_req = 1'b0;
    endtask

    task automatic wait_result(input string tag);
        do @(negedge clk); while (res_valid !== 1'b1);
        chk({tag, " R6 zero count"}, int'(cnt_zero), exp_cnt(0));
        chk({tag, " R6 full count"}, int'(cnt_full), exp_cnt(1));
        chk({tag, " R6 unknown count"}, int'(cnt_unk), exp_cnt(2));
        chk({tag, " R8 ovr flags"}, int'(ovr), exp_ovr(0) | (exp_ovr(1) << 1) | (exp_ovr(2) << 2));
        chk({tag, " R9 busy low at strobe"}, int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        chk("R1 integ_rst after reset", int'(integ_rst), 1);
        chk("R2 sel after reset", int'(sel), 0);
        chk("R4 busy after reset", int'(busy), 0);
        chk("R9 res_valid after reset", int'(res_valid), 0);
        run_chk = 1'b1;
        repeat (37) @(negedge clk);

        // R5 R6: plain conversion with distinct thresholds
        thr = '{5, 30, 50};
        pulse_req();
        repeat (60) @(negedge clk);
        conv_req = 1'b1;                    // R10: request while busy is ignored
        @(negedge clk) conv_req = 1'b0;
        wait_result("conv1");
        repeat (30) @(negedge clk);

        // R6 R8: ramp-end boundaries, earliest trip
        thr = '{0, 57, 58};
        pulse_req();
        wait_result("conv2 boundary");
        repeat (10) @(negedge clk);

        // R7: toggles after the first trip
        thr = '{10, 20, 3};
        glitch = 1'b1;
        pulse_req();
        wait_result("conv3 R7 glitch");
        glitch = 1'b0;
        begin
            int hz;
            int hu;
            hz = int'(cnt_zero);
            hu = int'(cnt_unk);
            repeat (25) @(negedge clk);
            chk("R9 counts held while idle (zero)", int'(cnt_zero), hz);
            chk("R9 counts held while idle (unknown)", int'(cnt_unk), hu);
        end

        // R8: full-scale comparator already high before its ramp
        thr = '{12, 25, 40};
        hi_src = 1;
        pulse_req();
        wait_result("conv4 stuck-high");
        hi_src = -1;

        // R4: request in the last cycle of a period uses the window that begins next
        thr = '{7, 8, 9};
        do @(negedge clk); while (mph != PERIOD - 1);
        conv_req = 1'b1;
        @(negedge clk) conv_req = 1'b0;
        chk("R4 busy right after late request", int'(busy), 1);
        repeat (DEAD_LEN) @(negedge clk);
        chk("R3 dead time still all low", int'(sel), 0);
        @(negedge clk);
        chk("R4 zero select in next window", int'(sel), 1);
        wait_result("conv5 late request");
        repeat (20) @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule